// File: doc/BRIEF.md
# Fetch Line Address Sequencer

This block generates the instruction-fetch request stream for one hardware thread. Each request names a starting byte address, a byte count, a running line number and the two tags (stream and prediction) that were current when the request was formed. Downstream logic uses the tags to throw away lines that belong to a stream that has since been abandoned. After every issued request the fetch address moves forward by the issued length, so a fetch that starts partway into an aligned snap line first finishes that line with a short request and then proceeds in aligned steps.

Two control inputs steer the sequencer. A redirect carries a new target address, a reason code and fresh stream and prediction tags; depending on the reason it leaves the sequencer running, halted, or waiting for a new program counter. A wake-up carries a program counter and restarts a halted sequencer. A level-sensitive credit input stands for free space further down the fetch path: while it is low, nothing new is formed. The request leaves through a valid/ready output: once `req_valid` is high, the payload is held unchanged until the cycle in which `req_ready` is also high, and a new request can be formed in that same cycle.

Top module: `fetch_line_seq`

## Requirements
- R1: After reset `fetch_state` reads halted (2'd0), `req_valid` is low, the stream and prediction tags are zero and the first request issued carries line number 0.
- R2: No request crosses a snap boundary: (req_addr mod SNAP_BYTES) + req_len never exceeds SNAP_BYTES.
- R3: No request is longer than WIDTH_BYTES, and no request has zero length.
- R4: A fetch address with a nonzero offset into a snap line yields a request of length min(SNAP_BYTES - offset, WIDTH_BYTES).
- R5: Each new request starts at the previous request's address plus its length, unless a redirect or wake-up has loaded a new address in between.
- R6: A redirect always loads its target as the next fetch address and replaces the stored stream and prediction tags; reason 2'b00 (branch) sets the state to running (2'd2). Requests formed afterwards carry the new tags.
- R7: A redirect with reason 2'b01 (halt) or 2'b10 (suspend) sets the state to halted and no new request is formed until the sequencer is restarted.
- R8: A redirect with reason 2'b11 sets the state to waiting-for-PC (2'd1); in that state a wake-up is ignored and only a redirect leaves it.
- R9: A wake-up while halted loads its program counter and sets the state to running; a wake-up in any other state has no effect on state or address.
- R10: The line number increases by exactly one for each request formed, across redirects and wake-ups.
- R11: At most one request is formed per cycle, and only in a cycle where the state is running, credit is high, no redirect is present, and the output slot is empty or being accepted.
- R12: While `req_valid` is high and `req_ready` is low the whole payload stays stable; a redirect does not cancel a request already in the output slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Redirect present this cycle |
| redir_reason | input | 2 | 00 branch, 01 halt, 10 suspend, 11 wait for PC |
| redir_target | input | ADDR_W | New fetch address |
| redir_stream | input | SEQ_W | New stream tag |
| redir_pred | input | SEQ_W | New prediction tag |
| wake_valid | input | 1 | Wake-up present this cycle |
| wake_pc | input | ADDR_W | Program counter supplied with the wake-up |
| issue_credit | input | 1 | Downstream space available |
| req_valid | output | 1 | Request slot holds a request |
| req_ready | input | 1 | Consumer takes the request this cycle |
| req_addr | output | ADDR_W | Request start byte address |
| req_len | output | LEN_W | Request length in bytes |
| req_lseq | output | LSEQ_W | Line number |
| req_stream | output | SEQ_W | Stream tag at formation |
| req_pred | output | SEQ_W | Prediction tag at formation |
| fetch_state | output | 2 | 0 halted, 1 waiting for PC, 2 running |

## Verification
The assertions assume the consumer obeys the output rule from its side only as far as `req_ready` goes, and that redirect and wake-up are single-cycle pulses; they do not assume credit or ready are ever high. The stimulus drives every input one time unit after the rising edge, keeps credit low whenever a redirect or wake-up is pulsed so the issue count per credit window is exact, and holds `req_ready` high except in the deliberate stall episode, where credit is held for several cycles to show only one request is formed.

// File: rtl/fls_pkg.sv
package fls_pkg;
  typedef enum logic [1:0] {
    FS_HALTED  = 2'd0,
    FS_WAIT_PC = 2'd1,
    FS_RUNNING = 2'd2
  } fetch_state_e;

  typedef enum logic [1:0] {
    RSN_BRANCH   = 2'd0,
    RSN_HALT     = 2'd1,
    RSN_SUSPEND  = 2'd2,
    RSN_AWAIT_PC = 2'd3
  } redir_reason_e;
endpackage

// File: rtl/fls_clip.sv
module fls_clip #(
  parameter int ADDR_W      = 32,
  parameter int SNAP_BYTES  = 16,
  parameter int WIDTH_BYTES = 8,
  parameter int LEN_W       = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  len
);
  localparam int OFF_W = (SNAP_BYTES > 1) ? $clog2(SNAP_BYTES) : 1;

  logic [OFF_W-1:0] offset;
  logic [LEN_W-1:0] room;

  // Bytes left before the next snap boundary, then capped by the fetch width.
  always_comb begin
    offset = addr[OFF_W-1:0];
    room   = LEN_W'(SNAP_BYTES) - LEN_W'(offset);
    if (room > LEN_W'(WIDTH_BYTES)) len = LEN_W'(WIDTH_BYTES);
    else                            len = room;
  end
endmodule

// File: rtl/fls_ctrl.sv
module fls_ctrl
  import fls_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEQ_W  = 8,
  parameter int LSEQ_W = 16,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_valid,
  input  logic [1:0]        redir_reason,
  input  logic [ADDR_W-1:0] redir_target,
  input  logic [SEQ_W-1:0]  redir_stream,
  input  logic [SEQ_W-1:0]  redir_pred,
  input  logic              wake_valid,
  input  logic [ADDR_W-1:0] wake_pc,
  input  logic              issue,
  input  logic [LEN_W-1:0]  issue_len,
  output fetch_state_e      state,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic [SEQ_W-1:0]  stream_tag,
  output logic [SEQ_W-1:0]  pred_tag,
  output logic [LSEQ_W-1:0] line_num
);
  fetch_state_e next_after_redir;

  always_comb begin
    unique case (redir_reason_e'(redir_reason))
      RSN_BRANCH:   next_after_redir = FS_RUNNING;
      RSN_HALT:     next_after_redir = FS_HALTED;
      RSN_SUSPEND:  next_after_redir = FS_HALTED;
      default:      next_after_redir = FS_WAIT_PC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= FS_HALTED;
      fetch_pc   <= '0;
      stream_tag <= '0;
      pred_tag   <= '0;
    end else if (redir_valid) begin
      state      <= next_after_redir;
      fetch_pc   <= redir_target;
      stream_tag <= redir_stream;
      pred_tag   <= redir_pred;
    end else if (wake_valid && state == FS_HALTED) begin
      state    <= FS_RUNNING;
      fetch_pc <= wake_pc;
    end else if (issue) begin
      fetch_pc <= fetch_pc + ADDR_W'(issue_len);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     line_num <= '0;
    else if (issue) line_num <= line_num + 1'b1;
  end

  // R7: halt or suspend redirect leaves the sequencer halted
  a_r7_halt_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && (redir_reason == 2'd1 || redir_reason == 2'd2)) |=> state == FS_HALTED);

  // R8: only a redirect leaves the waiting-for-PC state
  a_r8_wait_pc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FS_WAIT_PC && !redir_valid) |=> state == FS_WAIT_PC);

  // R11: the top asks for an issue only while running
  a_r11_issue_running: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (state == FS_RUNNING && !redir_valid));

  // R9: wake-up outside halted leaves the address alone
  a_r9_wake_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_valid && !redir_valid && !issue && state != FS_HALTED) |=> $stable(fetch_pc));
endmodule

// File: rtl/fls_slot.sv
module fls_slot #(
  parameter int ADDR_W      = 32,
  parameter int SEQ_W       = 8,
  parameter int LSEQ_W      = 16,
  parameter int LEN_W       = 5,
  parameter int SNAP_BYTES  = 16,
  parameter int WIDTH_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [LSEQ_W-1:0] in_lseq,
  input  logic [SEQ_W-1:0]  in_stream,
  input  logic [SEQ_W-1:0]  in_pred,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  len,
  output logic [LSEQ_W-1:0] lseq,
  output logic [SEQ_W-1:0]  stream,
  output logic [SEQ_W-1:0]  pred
);
  localparam int OFF_W = (SNAP_BYTES > 1) ? $clog2(SNAP_BYTES) : 1;

  always_ff @(posedge clk) begin
    if (!rst_n)     valid <= 1'b0;
    else if (load)  valid <= 1'b1;
    else if (ready) valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr   <= '0;
      len    <= '0;
      lseq   <= '0;
      stream <= '0;
      pred   <= '0;
    end else if (load) begin
      addr   <= in_addr;
      len    <= in_len;
      lseq   <= in_lseq;
      stream <= in_stream;
      pred   <= in_pred;
    end
  end

  // Observer of accepted line numbers for the step check.
  logic              seen_any;
  logic [LSEQ_W-1:0] last_lseq;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_any  <= 1'b0;
      last_lseq <= '0;
    end else if (valid && ready) begin
      seen_any  <= 1'b1;
      last_lseq <= lseq;
    end
  end

  // R12: a stalled request keeps its payload
  a_r12_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(addr) && $stable(len) && $stable(lseq)
                           && $stable(stream) && $stable(pred)));

  // R2: the request ends at or before the snap boundary
  a_r2_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((LEN_W + 1)'(addr[OFF_W-1:0]) + (LEN_W + 1)'(len)) <= (LEN_W + 1)'(SNAP_BYTES));

  // R3: width cap and nonzero length
  a_r3_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (len != '0 && len <= LEN_W'(WIDTH_BYTES)));

  // R10: consecutive accepted requests are numbered one apart
  a_r10_lseq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && seen_any) |-> lseq == last_lseq + 1'b1);
endmodule

// File: rtl/fetch_line_seq.sv
module fetch_line_seq
  import fls_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SNAP_BYTES  = 16,
  parameter int WIDTH_BYTES = 8,
  parameter int SEQ_W       = 8,
  parameter int LSEQ_W      = 16,
  localparam int MAX_LEN    = (SNAP_BYTES > WIDTH_BYTES) ? SNAP_BYTES : WIDTH_BYTES,
  localparam int LEN_W      = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_valid,
  input  logic [1:0]        redir_reason,
  input  logic [ADDR_W-1:0] redir_target,
  input  logic [SEQ_W-1:0]  redir_stream,
  input  logic [SEQ_W-1:0]  redir_pred,
  input  logic              wake_valid,
  input  logic [ADDR_W-1:0] wake_pc,
  input  logic              issue_credit,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [LSEQ_W-1:0] req_lseq,
  output logic [SEQ_W-1:0]  req_stream,
  output logic [SEQ_W-1:0]  req_pred,
  output logic [1:0]        fetch_state
);
  fetch_state_e      state;
  logic [ADDR_W-1:0] fetch_pc;
  logic [SEQ_W-1:0]  stream_tag;
  logic [SEQ_W-1:0]  pred_tag;
  logic [LSEQ_W-1:0] line_num;
  logic [LEN_W-1:0]  clip_len;
  logic              issue;

  assign issue = (state == FS_RUNNING) && issue_credit && !redir_valid
                 && (!req_valid || req_ready);
  assign fetch_state = state;

  fls_clip #(
    .ADDR_W(ADDR_W), .SNAP_BYTES(SNAP_BYTES), .WIDTH_BYTES(WIDTH_BYTES), .LEN_W(LEN_W)
  ) clip_i (
    .addr(fetch_pc),
    .len (clip_len)
  );

  fls_ctrl #(
    .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .LSEQ_W(LSEQ_W), .LEN_W(LEN_W)
  ) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .redir_valid (redir_valid),
    .redir_reason(redir_reason),
    .redir_target(redir_target),
    .redir_stream(redir_stream),
    .redir_pred  (redir_pred),
    .wake_valid  (wake_valid),
    .wake_pc     (wake_pc),
    .issue       (issue),
    .issue_len   (clip_len),
    .state       (state),
    .fetch_pc    (fetch_pc),
    .stream_tag  (stream_tag),
    .pred_tag    (pred_tag),
    .line_num    (line_num)
  );

  fls_slot #(
    .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .LSEQ_W(LSEQ_W), .LEN_W(LEN_W),
    .SNAP_BYTES(SNAP_BYTES), .WIDTH_BYTES(WIDTH_BYTES)
  ) slot_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (issue),
    .in_addr  (fetch_pc),
    .in_len   (clip_len),
    .in_lseq  (line_num),
    .in_stream(stream_tag),
    .in_pred  (pred_tag),
    .ready    (req_ready),
    .valid    (req_valid),
    .addr     (req_addr),
    .len      (req_len),
    .lseq     (req_lseq),
    .stream   (req_stream),
    .pred     (req_pred)
  );

  // R11: no new request appears unless the sequencer was running with credit
  a_r11_form_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !(state == FS_RUNNING && issue_credit)) |=> !req_valid);

  // R5: back-to-back issues without redirect or wake are contiguous
  a_r5_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && $past(issue) && !$past(redir_valid) && !$past(wake_valid))
      |-> fetch_pc == $past(fetch_pc) + ADDR_W'($past(clip_len)));
endmodule

// File: tb/fetch_line_seq_tb_top.sv
module fetch_line_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SNAP = 16;
  localparam int WID = 8;
  localparam int SW = 8;
  localparam int LW = 16;
  localparam int LENW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic redir_valid = 1'b0;
  logic [1:0] redir_reason = 2'd0;
  logic [AW-1:0] redir_target = '0;
  logic [SW-1:0] redir_stream = '0;
  logic [SW-1:0] redir_pred = '0;
  logic wake_valid = 1'b0;
  logic [AW-1:0] wake_pc = '0;
  logic issue_credit = 1'b0;
  logic req_ready = 1'b1;
  logic req_valid;
  logic [AW-1:0] req_addr;
  logic [LENW-1:0] req_len;
  logic [LW-1:0] req_lseq;
  logic [SW-1:0] req_stream;
  logic [SW-1:0] req_pred;
  logic [1:0] fetch_state;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_line_seq #(.ADDR_W(AW), .SNAP_BYTES(SNAP), .WIDTH_BYTES(WID),
                   .SEQ_W(SW), .LSEQ_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .redir_valid(redir_valid), .redir_reason(redir_reason), .redir_target(redir_target),
    .redir_stream(redir_stream), .redir_pred(redir_pred),
    .wake_valid(wake_valid), .wake_pc(wake_pc), .issue_credit(issue_credit),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .req_lseq(req_lseq), .req_stream(req_stream), .req_pred(req_pred),
    .fetch_state(fetch_state)
  );

  typedef struct {
    logic [AW-1:0] addr;
    int            len;
    logic [LW-1:0] lseq;
    logic [SW-1:0] stream;
    logic [SW-1:0] pred;
    string         tag;
  } exp_t;

  exp_t sb[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench-side model of the fetch position
  logic [AW-1:0] m_pc = '0;
  logic [LW-1:0] m_lseq = '0;
  logic [SW-1:0] m_stream = '0;
  logic [SW-1:0] m_pred = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int exp_len(input logic [AW-1:0] a);
    int room;
    room = SNAP - int'(a % SNAP);
    return (room > WID) ? WID : room;
  endfunction

  task automatic push_one(input string tag);
    exp_t e;
    e.addr = m_pc; e.len = exp_len(m_pc); e.lseq = m_lseq;
    e.stream = m_stream; e.pred = m_pred; e.tag = tag;
    sb.push_back(e);
    m_pc = m_pc + AW'(e.len);
    m_lseq = m_lseq + 1'b1;
  endtask

  task automatic issue_n(input int n, input string tag);
    for (int i = 0; i < n; i++) push_one(tag);
    issue_credit = 1'b1;
    repeat (n) step();
    issue_credit = 1'b0;
    repeat (3) step();
  endtask

  task automatic redirect(input logic [1:0] rsn, input logic [AW-1:0] tgt,
                          input logic [SW-1:0] s, input logic [SW-1:0] p);
    redir_valid = 1'b1; redir_reason = rsn; redir_target = tgt;
    redir_stream = s; redir_pred = p;
    step();
    redir_valid = 1'b0;
    step();
    m_pc = tgt; m_stream = s; m_pred = p;
  endtask

  task automatic wake(input logic [AW-1:0] pc, input bit takes);
    wake_valid = 1'b1; wake_pc = pc;
    step();
    wake_valid = 1'b0;
    step();
    if (takes) m_pc = pc;
  endtask

  // monitor: compares every accepted request against the scoreboard
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R11 unexpected request", longint'(req_addr), 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(req_addr == e.addr, {e.tag, " addr"}, longint'(req_addr), longint'(e.addr));
        chk(int'(req_len) == e.len, {e.tag, " len"}, longint'(req_len), longint'(e.len));
        chk(req_lseq == e.lseq, {e.tag, " R10 lseq"}, longint'(req_lseq), longint'(e.lseq));
        chk(req_stream == e.stream && req_pred == e.pred, {e.tag, " R6 tags"},
            longint'({req_stream, req_pred}), longint'({e.stream, e.pred}));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  logic [AW-1:0] held_addr;
  logic [LW-1:0] held_lseq;
  logic [SW-1:0] held_stream;

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1: reset state
    chk(fetch_state == 2'd0, "R1 state", fetch_state, 0);
    chk(req_valid == 1'b0, "R1 valid", req_valid, 0);

    // R11: credit while halted forms nothing
    issue_credit = 1'b1;
    repeat (3) step();
    issue_credit = 1'b0;
    step();
    chk(req_valid == 1'b0, "R11 halted no issue", req_valid, 0);

    // R9: wake from halted; R4/R2/R3/R5 partial and aligned stream
    wake(32'h1006, 1'b1);
    chk(fetch_state == 2'd2, "R9 wake runs", fetch_state, 2);
    issue_n(5, "R4 R5 R2 R3 stream");

    // R9: wake while running ignored
    wake(32'h5000, 1'b0);
    chk(fetch_state == 2'd2, "R9 wake running state", fetch_state, 2);
    issue_n(2, "R9 ignored wake");

    // R6: branch redirect with mid-line target
    redirect(2'b00, 32'h200D, 8'd5, 8'd9);
    chk(fetch_state == 2'd2, "R6 branch runs", fetch_state, 2);
    issue_n(3, "R6 new stream");

    // R7: halt
    redirect(2'b01, 32'h3000, 8'd6, 8'd1);
    chk(fetch_state == 2'd0, "R7 halt state", fetch_state, 0);
    issue_credit = 1'b1;
    repeat (3) step();
    issue_credit = 1'b0;
    step();
    chk(req_valid == 1'b0, "R7 halted no issue", req_valid, 0);
    wake(32'h3000, 1'b1);
    issue_n(1, "R6 tags kept through halt");

    // R7: suspend
    redirect(2'b10, 32'h3100, 8'd7, 8'd2);
    chk(fetch_state == 2'd0, "R7 suspend state", fetch_state, 0);
    wake(32'h3100, 1'b1);

    // R8: wait for PC, wake ignored
    redirect(2'b11, 32'h3200, 8'd8, 8'd3);
    chk(fetch_state == 2'd1, "R8 wait state", fetch_state, 1);
    wake(32'h7000, 1'b0);
    chk(fetch_state == 2'd1, "R8 wake ignored", fetch_state, 1);
    issue_credit = 1'b1;
    repeat (3) step();
    issue_credit = 1'b0;
    step();
    chk(req_valid == 1'b0, "R8 no issue while waiting", req_valid, 0);
    redirect(2'b00, 32'h4004, 8'd8, 8'd3);
    chk(fetch_state == 2'd2, "R8 redirect leaves wait", fetch_state, 2);
    issue_n(1, "R8 resume");

    // R12 / R11: stall with credit held, then redirect under a pending request
    req_ready = 1'b0;
    push_one("R12 stalled request");
    issue_credit = 1'b1;
    repeat (3) step();
    issue_credit = 1'b0;
    chk(req_valid == 1'b1, "R12 valid held", req_valid, 1);
    chk(req_addr == 32'h400C, "R12 addr", req_addr, 32'h400C);
    held_addr = req_addr; held_lseq = req_lseq; held_stream = req_stream;
    repeat (2) step();
    chk(req_addr == held_addr && req_lseq == held_lseq, "R12 stable", req_lseq, held_lseq);
    redirect(2'b00, 32'h6000, 8'd9, 8'd4);
    chk(req_valid == 1'b1 && req_stream == held_stream, "R12 survives redirect",
        req_stream, held_stream);
    req_ready = 1'b1;
    repeat (2) step();
    chk(req_valid == 1'b0, "R12 drained", req_valid, 0);
    issue_n(1, "R11 one per stall");

    repeat (4) step();
    chk(sb.size() == 0, "R11 all expected seen", sb.size(), 0);
    finish_run();
  end
endmodule